// File: doc/BRIEF.md
# Input Capture Channel with Event Prescaler

This block is one capture channel of a general-purpose timer. A two-bit mode field chooses what the channel does. The value zero makes the channel an output, and the capture logic then stays idle. The other three values each pick a capture source: the channel's own input, the input of the neighbouring channel, or the timer's internal trigger. The mode field accepts a write only while the channel enable is low.

Rising edges on the chosen source are events. A prescaler counts the events and lets through one of every 1, 2, 4 or 8 of them. On each event it lets through, the free-running timer count is copied into the capture register and the capture flag is set. If that flag is still set when the next capture arrives, an overcapture flag is also raised. Both flags stay set until the clear strobe is given.

Top module: `icap_channel`

## Requirements
- R1: When the active mode is 00 (output use), no capture happens: `cap_val_o` holds its value and neither flag is set, whatever the three sources do.
- R2: Mode 01 captures on `src_own_i`, mode 10 on `src_nbr_i` and mode 11 on `src_trg_i`. Edges on the two sources that are not selected have no effect.
- R3: A mode write (`mode_wr_i` high, value on `mode_wdata_i`) is accepted only in a cycle where `chan_en_i` is 0. A write made while the channel is enabled is ignored, and the old source stays in use.
- R4: Prescaler field `psc_i` values 00, 01, 10 and 11 give one capture per 1, 2, 4 and 8 events. The capture happens on the last event of each group.
- R5: An event is a rising edge of the selected source. Sources are sampled on every clock edge. The capture occurs at the second clock edge at which the source is sampled high, and it stores `cnt_i` as applied just before that edge. A source held high produces only one event.
- R6: While `chan_en_i` is 0, events are ignored and the prescaler's event count returns to zero.
- R7: A change of `psc_i` while the channel is enabled returns the event count to zero, so counting restarts with the new setting.
- R8: A capture sets `cap_flag_o`. If `cap_flag_o` was already set at that capture, `over_flag_o` is also set.
- R9: A cycle with `flag_clr_i` high and no capture clears both flags. If a capture falls in the same cycle as the clear, `cap_flag_o` ends up set and `over_flag_o` ends up cleared.
- R10: Synchronous active-high reset clears `cap_val_o`, both flags, the event count and the mode (the mode becomes 00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | CNT_W | Timer count value to be captured |
| src_own_i | input | 1 | The channel's own input (mode 01) |
| src_nbr_i | input | 1 | The neighbouring channel's input (mode 10) |
| src_trg_i | input | 1 | Internal trigger source (mode 11) |
| chan_en_i | input | 1 | Channel enable |
| mode_wr_i | input | 1 | Write strobe for the mode field |
| mode_wdata_i | input | 2 | Mode value to write |
| psc_i | input | PSC_W | Prescaler setting |
| flag_clr_i | input | 1 | Clears both flags |
| cap_val_o | output | CNT_W | Last captured count value |
| cap_flag_o | output | 1 | Capture flag |
| over_flag_o | output | 1 | Overcapture flag |

## Verification
Each source edge is first seen by the sampling register at one clock edge. The capture register and the flags change one edge after that, so a capture result is due two edges after the source rises. Mode writes, enable changes and prescaler changes take effect at the next edge. The bench drives every input on the falling clock edge and holds `cnt_i` steady from the moment a pulse starts. It reads results only on a later falling edge, after the whole pulse sequence has ended, so every due edge has passed before a comparison is made. The one same-cycle case, a clear that lands on the capture edge, is produced by raising the clear on the falling edge between the sampling edge and the capture edge.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int SEL_W = 2;
  localparam int NSRC  = (1 << SEL_W) - 1;

  typedef enum logic [SEL_W-1:0] {
    MODE_OUTPUT   = 2'b00,
    MODE_OWN      = 2'b01,
    MODE_NEIGHBOR = 2'b10,
    MODE_TRIGGER  = 2'b11
  } icap_mode_e;
endpackage

// File: rtl/icap_src_path.sv
module icap_src_path
  import icap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  chan_en_i,
  input  logic                  mode_wr_i,
  input  logic [SEL_W-1:0]      mode_wdata_i,
  input  logic [NSRC-1:0]       src_vec_i,
  output icap_mode_e            mode_o,
  output logic                  event_o
);
  icap_mode_e      mode_q;
  logic [NSRC-1:0] hit;
  logic            pick;
  logic            samp_q;
  logic            prev_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_OUTPUT;
    else if (mode_wr_i && !chan_en_i) mode_q <= icap_mode_e'(mode_wdata_i);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_route
    assign hit[g] = (mode_q == icap_mode_e'(SEL_W'(g + 1))) && src_vec_i[g];
  end
  assign pick = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= pick;
      prev_q <= samp_q;
    end
  end

  assign event_o = samp_q && !prev_q;
  assign mode_o  = mode_q;

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    chan_en_i |=> $stable(mode_q)); // R3
  AST_ONE_EVENT_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o); // R5
endmodule

// File: rtl/icap_prescaler.sv
module icap_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             event_i,
  output logic             fire_o
);
  localparam int EVC_W = (1 << PSC_W) - 1;

  logic [PSC_W-1:0] psc_q;
  logic [EVC_W-1:0] evc_q;
  logic [EVC_W-1:0] last_cnt;
  logic             psc_chg;

  assign last_cnt = EVC_W'((1 << psc_q) - 1);
  assign psc_chg  = (psc_i != psc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      evc_q <= '0;
    end else begin
      psc_q <= psc_i;
      if (!en_i || psc_chg)  evc_q <= '0;
      else if (event_i)      evc_q <= (evc_q == last_cnt) ? '0 : evc_q + 1'b1;
    end
  end

  assign fire_o = en_i && !psc_chg && event_i && (evc_q == last_cnt);

  AST_PSC_RANGE: assert property (@(posedge clk) disable iff (rst)
    evc_q <= last_cnt); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (evc_q == '0)); // R6
  AST_PSC_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    psc_chg |=> (evc_q == '0)); // R7
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             src_own_i,
  input  logic             src_nbr_i,
  input  logic             src_trg_i,
  input  logic             chan_en_i,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_wdata_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             over_flag_o
);
  icap_mode_e      mode;
  logic            evt;
  logic            fire;
  logic            active;
  logic [NSRC-1:0] srcs;

  assign srcs   = {src_trg_i, src_nbr_i, src_own_i};
  assign active = chan_en_i && (mode != MODE_OUTPUT);

  icap_src_path u_src (
    .clk          (clk),
    .rst          (rst),
    .chan_en_i    (chan_en_i),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .src_vec_i    (srcs),
    .mode_o       (mode),
    .event_o      (evt)
  );

  icap_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .en_i    (active),
    .psc_i   (psc_i),
    .event_i (evt),
    .fire_o  (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val_o   <= '0;
      cap_flag_o  <= 1'b0;
      over_flag_o <= 1'b0;
    end else if (fire) begin
      cap_val_o   <= cnt_i;
      cap_flag_o  <= 1'b1;
      over_flag_o <= !flag_clr_i && (over_flag_o || cap_flag_o);
    end else if (flag_clr_i) begin
      cap_flag_o  <= 1'b0;
      over_flag_o <= 1'b0;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OUTPUT) |=> $stable(cap_val_o)); // R1
  AST_CAPTURE_STORES: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cap_flag_o && cap_val_o == $past(cnt_i))); // R5
  AST_OVER_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(over_flag_o) |-> $past(cap_flag_o)); // R8
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !fire) |=> (!cap_flag_o && !over_flag_o)); // R9
endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;
  localparam int CNT_W = 16;
  localparam int PSC_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt_i = '0;
  logic [2:0]       srcs = '0;
  logic             chan_en_i = 1'b0;
  logic             mode_wr_i = 1'b0;
  logic [1:0]       mode_wdata_i = '0;
  logic [PSC_W-1:0] psc_i = '0;
  logic             flag_clr_i = 1'b0;
  logic [CNT_W-1:0] cap_val_o;
  logic             cap_flag_o;
  logic             over_flag_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  icap_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
    .clk(clk), .rst(rst), .cnt_i(cnt_i),
    .src_own_i(srcs[0]), .src_nbr_i(srcs[1]), .src_trg_i(srcs[2]),
    .chan_en_i(chan_en_i), .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
    .psc_i(psc_i), .flag_clr_i(flag_clr_i),
    .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o), .over_flag_o(over_flag_o)
  );

  // {mode[9:8], psc[7:6], source index 1..3 [5:4], pulse count [3:0]}
  localparam int NVEC = 9;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b01, 2'b00, 2'd1, 4'd1},   // R2 own source, every event
    {2'b01, 2'b01, 2'd1, 4'd3},   // R4 divide by 2
    {2'b10, 2'b10, 2'd2, 4'd8},   // R4 divide by 4, two captures
    {2'b11, 2'b11, 2'd3, 4'd8},   // R4 divide by 8
    {2'b11, 2'b11, 2'd3, 4'd7},   // R4 one short of 8
    {2'b10, 2'b00, 2'd1, 4'd3},   // R2 unselected source
    {2'b00, 2'b00, 2'd1, 4'd2},   // R1 output mode
    {2'b01, 2'b00, 2'd3, 4'd2},   // R2 unselected trigger
    {2'b11, 2'b00, 2'd3, 4'd2}    // R8 overcapture
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] mode, input logic [PSC_W-1:0] psc);
    @(negedge clk);
    chan_en_i = 1'b0; mode_wr_i = 1'b1; mode_wdata_i = mode; psc_i = psc; flag_clr_i = 1'b1;
    @(negedge clk);
    mode_wr_i = 1'b0; flag_clr_i = 1'b0; chan_en_i = 1'b1;
  endtask

  task automatic pulse(input int idx, input logic [CNT_W-1:0] v);
    @(negedge clk);
    cnt_i = v; srcs[idx-1] = 1'b1;
    @(negedge clk);
    srcs[idx-1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 value", 32'(cap_val_o), 0);
    check("R10 flag", 32'(cap_flag_o), 0);
    check("R10 over", 32'(over_flag_o), 0);

    for (int vi = 0; vi < NVEC; vi++) begin
      logic [1:0] m; logic [1:0] p; int src; int n; int lim; int caps;
      {m, p} = VEC[vi][9:6];
      src = int'(VEC[vi][5:4]);
      n   = int'(VEC[vi][3:0]);
      configure(m, p);
      for (int i = 0; i < n; i++) pulse(src, CNT_W'(vi * 256 + i + 1));
      lim  = 1 << p;
      caps = (m != 2'b00 && int'(m) == src) ? n / lim : 0;
      check("R2/R4 flag", 32'(cap_flag_o), 32'(caps > 0));
      check("R8 over", 32'(over_flag_o), 32'(caps > 1));
      if (caps > 0) check("R5 value", 32'(cap_val_o), 32'(vi * 256 + caps * lim));
      else          check("R1 no capture", 32'(cap_flag_o), 0);
    end

    // R3: a mode write while enabled is ignored
    configure(2'b01, 2'b00);
    @(negedge clk); mode_wr_i = 1'b1; mode_wdata_i = 2'b10;
    @(negedge clk); mode_wr_i = 1'b0;
    pulse(1, 16'h1111);
    check("R3 old source kept", 32'(cap_flag_o), 1);
    check("R3 value", 32'(cap_val_o), 32'h1111);
    @(negedge clk); flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    pulse(2, 16'h2222);
    check("R3 new source not used", 32'(cap_flag_o), 0);

    // R7: prescaler change restarts counting
    configure(2'b01, 2'b11);
    for (int i = 0; i < 3; i++) pulse(1, 16'h0300);
    @(negedge clk); psc_i = 2'b01;
    @(negedge clk);
    pulse(1, 16'h0301);
    check("R7 first after change", 32'(cap_flag_o), 0);
    pulse(1, 16'h0302);
    check("R7 second after change", 32'(cap_flag_o), 1);
    check("R7 value", 32'(cap_val_o), 32'h0302);

    // R6: disabling clears the count and drops events
    configure(2'b01, 2'b01);
    pulse(1, 16'h0600);
    @(negedge clk); chan_en_i = 1'b0;
    pulse(1, 16'h0601);
    @(negedge clk); chan_en_i = 1'b1;
    pulse(1, 16'h0602);
    check("R6 count cleared", 32'(cap_flag_o), 0);
    pulse(1, 16'h0603);
    check("R6 resumes", 32'(cap_val_o), 32'h0603);

    // R5: a held source gives one event
    configure(2'b01, 2'b00);
    @(negedge clk); cnt_i = 16'h0055; srcs[0] = 1'b1;
    repeat (6) @(negedge clk);
    srcs[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 held flag", 32'(cap_flag_o), 1);
    check("R5 held single", 32'(over_flag_o), 0);
    check("R5 held value", 32'(cap_val_o), 32'h0055);

    // R8, R9: overcapture then clear, then clear together with capture
    pulse(1, 16'h0066);
    check("R8 over set", 32'(over_flag_o), 1);
    @(negedge clk); flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    check("R9 flag cleared", 32'(cap_flag_o), 0);
    check("R9 over cleared", 32'(over_flag_o), 0);
    pulse(1, 16'h0070);
    @(negedge clk); pulse(1, 16'h0070);
    @(negedge clk); flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    pulse(1, 16'h0071);
    @(negedge clk); cnt_i = 16'h0077; srcs[0] = 1'b1;
    @(negedge clk); srcs[0] = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    @(negedge clk);
    check("R9 capture wins flag", 32'(cap_flag_o), 1);
    check("R9 over cleared on collision", 32'(over_flag_o), 0);
    check("R9 value", 32'(cap_val_o), 32'h0077);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule